// File: doc/BRIEF.md
# Interlaken Metaframe Frame Synchronizer

This receive-path block takes a stream of 67-bit words that an upstream stage has already block-aligned. Each word has a 2-bit header and a 64-bit payload. The block finds where the metaframes start and then keeps following them. It first hunts for a synchronization control word. It then confirms that a synchronization word returns at the same position in consecutive metaframes, and it declares metaframe lock once the required run of confirmations is complete.

While locked, the block checks each fixed slot of the metaframe against the word expected there:

- slot 0 must hold a synchronization word;
- slot 1 must hold a scrambler-state word;
- slot 2 must hold a skip word;
- the final slot must hold a diagnostic word.

The block raises one-cycle flags for a bad synchronization word, for a broken metaframe structure, for a skip word found in a payload slot, and for a skip slot that holds something else. It also marks the start of every metaframe with a pulse.

Runs of bad synchronization words or bad scrambler-state words make the block leave lock and hunt again. If upstream block lock drops, the block leaves lock at once and holds its sync-error flag high until block lock returns.

Top module: `mfs_framer`

## Requirements
- R1: A word is a control word only when its header is 2'b10. Word types are decoded as follows:
  - synchronization: the payload equals 64'h78F678F678F678F6;
  - scrambler-state: payload bits [63:56] equal 8'h28;
  - skip: payload bits [63:8] equal 56'h1E858585858585;
  - diagnostic: payload bits [63:56] equal 8'h19.

  Metaframe slot 0 is synchronization, slot 1 is scrambler-state, slot 2 is skip, slot MF_LEN-1 is diagnostic, and slots 3 to MF_LEN-2 are payload.
- R2: All outputs are registered. The flags for an accepted word appear on the clock edge that samples it. A synchronous active-high reset clears every output, counter and state.
- R3: When the block is not locked, a synchronization word starts a candidate alignment at slot 0. mf_locked rises together with the LOCK_GOOD-th consecutive synchronization word found at slot 0 (default 4).
- R4: Before lock, a synchronization word at any non-zero slot restarts the candidate with a count of one. A word at slot 0 that is not a synchronization word drops the candidate, and the block hunts again.
- R5: mf_start is high for one cycle for each slot-0 word while locked, including the word that completes lock. It is not raised for the slot-0 word that ends lock.
- R6: While locked, each slot-0 word that is not a synchronization word raises sync_word_err for one cycle. SYNC_BAD_MAX consecutive such words (default 4) end lock. A good synchronization word clears the run.
- R7: While locked, mf_struct_err pulses when slot 1 is not a scrambler-state word or the last slot is not a diagnostic word. SCR_BAD_MAX consecutive bad scrambler-state words (default 3) end lock.
- R8: While locked, skip_misplaced pulses when a skip word arrives in a payload slot.
- R9: While locked, skip_missing pulses when slot 2 holds anything other than a skip word.
- R10: While blk_lock_in is low, mf_locked is low, all counters are cleared, and the block returns to hunting. sync_word_err is held high and the other flags are low. Normal updates resume on the first cycle with blk_lock_in high.
- R11: A cycle with blk_valid low neither advances the slot position nor changes lock state, and it drives all pulse flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | Word strobe; header and payload are sampled when high |
| blk_hdr | input | 2 | Sync header of the word |
| blk_data | input | 64 | Payload of the word |
| blk_lock_in | input | 1 | Upstream block-lock status |
| mf_start | output | 1 | Pulse on the first word of each metaframe |
| mf_locked | output | 1 | Metaframe lock achieved |
| mf_struct_err | output | 1 | Bad scrambler-state or diagnostic word |
| sync_word_err | output | 1 | Bad synchronization word, or upstream block lock lost |
| skip_misplaced | output | 1 | Skip word seen in a payload slot |
| skip_missing | output | 1 | Skip slot held a non-skip word |

## Verification
The bench first plants a false synchronization word partway into a frame before the real alignment. A design that never restarts its candidate would lock on the wrong slot, or would never lock. It then injects runs of bad words that stop just short of the loss thresholds, followed by runs that reach them. This exposes off-by-one counters, and counters that fail to clear on a good word and so let isolated faults add up. Upstream block lock is also pulled low in the middle of a frame: a design that only pulses the sync-error flag, or keeps its slot position, would show up on the following reacquisition. Idle gaps inside locked frames catch a position counter that advances on invalid cycles.

// File: rtl/mfs_pkg.sv
`timescale 1ns/1ps
package mfs_pkg;
  localparam logic [1:0]  HDR_CTRL   = 2'b10;
  localparam logic [63:0] SYNC_WORD  = 64'h78F6_78F6_78F6_78F6;
  localparam logic [7:0]  SCR_TYPE   = 8'h28;
  localparam logic [7:0]  DIAG_TYPE  = 8'h19;
  localparam logic [55:0] SKIP_BODY  = 56'h1E_8585_8585_8585;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_TRACK   = 2'd2
  } sync_state_t;

  typedef enum logic [2:0] {
    SL_SYNC = 3'd0,
    SL_SCR  = 3'd1,
    SL_SKIP = 3'd2,
    SL_BODY = 3'd3,
    SL_DIAG = 3'd4
  } slot_t;

  typedef struct packed {
    logic is_sync;
    logic is_scr;
    logic is_skip;
    logic is_diag;
  } word_kind_t;
endpackage

// File: rtl/mfs_word_decode.sv
`timescale 1ns/1ps
module mfs_word_decode
  import mfs_pkg::*;
(
  input  logic [1:0]  hdr,
  input  logic [63:0] data,
  output word_kind_t  kind
);
  logic is_ctl;
  assign is_ctl = (hdr == HDR_CTRL);

  always_comb begin
    kind.is_sync = is_ctl && (data == SYNC_WORD);
    kind.is_scr  = is_ctl && (data[63:56] == SCR_TYPE);
    kind.is_skip = is_ctl && (data[63:8] == SKIP_BODY);
    kind.is_diag = is_ctl && (data[63:56] == DIAG_TYPE);
  end
endmodule

// File: rtl/mfs_slot_tracker.sv
`timescale 1ns/1ps
module mfs_slot_tracker
  import mfs_pkg::*;
#(
  parameter int MF_LEN = 2048
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clear,
  input  logic  restart,
  input  logic  advance,
  output slot_t slot
);
  localparam int PW = $clog2(MF_LEN);
  localparam logic [PW-1:0] LAST = PW'(MF_LEN - 1);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos_q <= '0;
    end else if (restart) begin
      pos_q <= PW'(1);
    end else if (advance) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + PW'(1);
    end
  end

  always_comb begin
    if (pos_q == '0)             slot = SL_SYNC;
    else if (pos_q == PW'(1))    slot = SL_SCR;
    else if (pos_q == PW'(2))    slot = SL_SKIP;
    else if (pos_q == LAST)      slot = SL_DIAG;
    else                         slot = SL_BODY;
  end
endmodule

// File: rtl/mfs_lock_ctrl.sv
`timescale 1ns/1ps
module mfs_lock_ctrl
  import mfs_pkg::*;
#(
  parameter int LOCK_GOOD    = 4,
  parameter int SYNC_BAD_MAX = 4,
  parameter int SCR_BAD_MAX  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       blk_valid,
  input  logic       blk_lock,
  input  word_kind_t kind,
  input  slot_t      slot,
  output logic       seek_clear,
  output logic       seek_restart,
  output logic       seek_advance,
  output logic       mf_start,
  output logic       mf_locked,
  output logic       struct_err,
  output logic       sync_err,
  output logic       skip_mis,
  output logic       skip_miss
);
  localparam int GW = $clog2(LOCK_GOOD + 1);
  localparam int SW = $clog2(SYNC_BAD_MAX + 1);
  localparam int CW = $clog2(SCR_BAD_MAX + 1);

  sync_state_t   st_q, st_n;
  logic [GW-1:0] good_q, good_n;
  logic [SW-1:0] sbad_q, sbad_n;
  logic [CW-1:0] cbad_q, cbad_n;
  logic start_n, struct_n, serr_n, mis_n, miss_n, drop;

  always_comb begin
    st_n         = st_q;
    good_n       = good_q;
    sbad_n       = sbad_q;
    cbad_n       = cbad_q;
    seek_clear   = 1'b0;
    seek_restart = 1'b0;
    seek_advance = 1'b0;
    start_n      = 1'b0;
    struct_n     = 1'b0;
    serr_n       = 1'b0;
    mis_n        = 1'b0;
    miss_n       = 1'b0;
    drop         = 1'b0;

    if (!blk_lock) begin
      st_n       = ST_HUNT;
      good_n     = '0;
      sbad_n     = '0;
      cbad_n     = '0;
      seek_clear = 1'b1;
      serr_n     = 1'b1;
    end else if (blk_valid) begin
      unique case (st_q)
        ST_HUNT: begin
          if (kind.is_sync) begin
            st_n         = ST_CONFIRM;
            good_n       = GW'(1);
            seek_restart = 1'b1;
          end
        end
        ST_CONFIRM: begin
          if (slot == SL_SYNC) begin
            if (kind.is_sync) begin
              seek_advance = 1'b1;
              if (good_q == GW'(LOCK_GOOD - 1)) begin
                st_n    = ST_TRACK;
                start_n = 1'b1;
                good_n  = '0;
                sbad_n  = '0;
                cbad_n  = '0;
              end else begin
                good_n = good_q + GW'(1);
              end
            end else begin
              st_n       = ST_HUNT;
              good_n     = '0;
              seek_clear = 1'b1;
            end
          end else if (kind.is_sync) begin
            seek_restart = 1'b1;
            good_n       = GW'(1);
          end else begin
            seek_advance = 1'b1;
          end
        end
        ST_TRACK: begin
          seek_advance = 1'b1;
          unique case (slot)
            SL_SYNC: begin
              start_n = 1'b1;
              if (kind.is_sync) begin
                sbad_n = '0;
              end else begin
                serr_n = 1'b1;
                sbad_n = sbad_q + SW'(1);
                if (sbad_q == SW'(SYNC_BAD_MAX - 1)) drop = 1'b1;
              end
            end
            SL_SCR: begin
              if (kind.is_scr) begin
                cbad_n = '0;
              end else begin
                struct_n = 1'b1;
                cbad_n   = cbad_q + CW'(1);
                if (cbad_q == CW'(SCR_BAD_MAX - 1)) drop = 1'b1;
              end
            end
            SL_SKIP: miss_n   = !kind.is_skip;
            SL_BODY: mis_n    = kind.is_skip;
            SL_DIAG: struct_n = !kind.is_diag;
            default: ;
          endcase
          if (drop) begin
            st_n       = ST_HUNT;
            good_n     = '0;
            sbad_n     = '0;
            cbad_n     = '0;
            seek_clear = 1'b1;
            start_n    = 1'b0;
          end
        end
        default: begin
          st_n       = ST_HUNT;
          seek_clear = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_HUNT;
      good_q     <= '0;
      sbad_q     <= '0;
      cbad_q     <= '0;
      mf_start   <= 1'b0;
      mf_locked  <= 1'b0;
      struct_err <= 1'b0;
      sync_err   <= 1'b0;
      skip_mis   <= 1'b0;
      skip_miss  <= 1'b0;
    end else begin
      st_q       <= st_n;
      good_q     <= good_n;
      sbad_q     <= sbad_n;
      cbad_q     <= cbad_n;
      mf_start   <= start_n;
      mf_locked  <= (st_n == ST_TRACK);
      struct_err <= struct_n;
      sync_err   <= serr_n;
      skip_mis   <= mis_n;
      skip_miss  <= miss_n;
    end
  end
endmodule

// File: rtl/mfs_framer.sv
`timescale 1ns/1ps
module mfs_framer
  import mfs_pkg::*;
#(
  parameter int MF_LEN       = 2048,
  parameter int LOCK_GOOD    = 4,
  parameter int SYNC_BAD_MAX = 4,
  parameter int SCR_BAD_MAX  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        blk_valid,
  input  logic [1:0]  blk_hdr,
  input  logic [63:0] blk_data,
  input  logic        blk_lock_in,
  output logic        mf_start,
  output logic        mf_locked,
  output logic        mf_struct_err,
  output logic        sync_word_err,
  output logic        skip_misplaced,
  output logic        skip_missing
);
  word_kind_t kind;
  slot_t      slot;
  logic       seek_clear, seek_restart, seek_advance;

  mfs_word_decode u_decode (
    .hdr  (blk_hdr),
    .data (blk_data),
    .kind (kind)
  );

  mfs_slot_tracker #(.MF_LEN(MF_LEN)) u_slot (
    .clk     (clk),
    .rst     (rst),
    .clear   (seek_clear),
    .restart (seek_restart),
    .advance (seek_advance),
    .slot    (slot)
  );

  mfs_lock_ctrl #(
    .LOCK_GOOD    (LOCK_GOOD),
    .SYNC_BAD_MAX (SYNC_BAD_MAX),
    .SCR_BAD_MAX  (SCR_BAD_MAX)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .blk_valid    (blk_valid),
    .blk_lock     (blk_lock_in),
    .kind         (kind),
    .slot         (slot),
    .seek_clear   (seek_clear),
    .seek_restart (seek_restart),
    .seek_advance (seek_advance),
    .mf_start     (mf_start),
    .mf_locked    (mf_locked),
    .struct_err   (mf_struct_err),
    .sync_err     (sync_word_err),
    .skip_mis     (skip_misplaced),
    .skip_miss    (skip_missing)
  );
endmodule

// File: rtl/mfs_framer_chk.sv
`timescale 1ns/1ps
module mfs_framer_chk (
  input logic        clk,
  input logic        rst,
  input logic        blk_valid,
  input logic [1:0]  blk_hdr,
  input logic [63:0] blk_data,
  input logic        blk_lock_in,
  input logic        mf_start,
  input logic        mf_locked,
  input logic        mf_struct_err,
  input logic        sync_word_err,
  input logic        skip_misplaced,
  input logic        skip_missing
);
  // R10
  blk_lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !blk_lock_in |=> (sync_word_err && !mf_locked));

  // R5
  start_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    mf_start |-> mf_locked);

  // R3
  lock_rise_marks_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_locked) |-> mf_start);

  // R11
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_lock_in && !blk_valid) |=>
      !(mf_start || mf_struct_err || skip_misplaced || skip_missing || sync_word_err));

  // R1
  slot_flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mf_start, mf_struct_err, skip_misplaced, skip_missing}));

  // R8
  skip_mis_locked_chk: assert property (@(posedge clk) disable iff (rst)
    skip_misplaced |-> mf_locked);

  // R9
  skip_miss_locked_chk: assert property (@(posedge clk) disable iff (rst)
    skip_missing |-> mf_locked);
endmodule

bind mfs_framer mfs_framer_chk u_chk (.*);

// File: tb/mfs_framer_tb.sv
`timescale 1ns/1ps
module mfs_framer_tb;
  localparam int L = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blk_valid = 1'b0;
  logic [1:0]  blk_hdr = 2'b01;
  logic [63:0] blk_data = '0;
  logic        blk_lock_in = 1'b1;
  logic        mf_start, mf_locked, mf_struct_err, sync_word_err, skip_misplaced, skip_missing;

  always #2.5 clk = ~clk;

  mfs_framer #(.MF_LEN(L)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .blk_valid      (blk_valid),
    .blk_hdr        (blk_hdr),
    .blk_data       (blk_data),
    .blk_lock_in    (blk_lock_in),
    .mf_start       (mf_start),
    .mf_locked      (mf_locked),
    .mf_struct_err  (mf_struct_err),
    .sync_word_err  (sync_word_err),
    .skip_misplaced (skip_misplaced),
    .skip_missing   (skip_missing)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  // reference state
  int m_st = 0, m_pos = 0, m_good = 0, m_sbad = 0, m_cbad = 0;

  localparam logic [63:0] W_SYNC = 64'h78F678F678F678F6;
  localparam logic [63:0] W_SCR  = {8'h28, 56'h00_1122_3344_5566};
  localparam logic [63:0] W_SKIP = {56'h1E858585858585, 8'h00};
  localparam logic [63:0] W_DIAG = {8'h19, 56'h00_0000_0000_0042};

  task automatic model(input bit v, input bit lk, input logic [1:0] h,
                       input logic [63:0] d, output logic [5:0] e);
    bit ctl, sy, sc, sk, dg;
    bit st, se, str, ms, mm, drop;
    ctl = (h == 2'b10);
    sy = ctl && d == W_SYNC;
    sc = ctl && d[63:56] == 8'h28;
    sk = ctl && d[63:8] == 56'h1E858585858585;
    dg = ctl && d[63:56] == 8'h19;
    st = 0; se = 0; str = 0; ms = 0; mm = 0; drop = 0;
    if (!lk) begin
      m_st = 0; m_pos = 0; m_good = 0; m_sbad = 0; m_cbad = 0; se = 1;
    end else if (v) begin
      if (m_st == 0) begin
        if (sy) begin m_st = 1; m_good = 1; m_pos = 1; end
      end else if (m_st == 1) begin
        if (m_pos == 0) begin
          if (sy) begin
            m_good++; m_pos = 1;
            if (m_good == 4) begin m_st = 2; st = 1; m_good = 0; m_sbad = 0; m_cbad = 0; end
          end else begin m_st = 0; m_good = 0; m_pos = 0; end
        end else if (sy) begin m_pos = 1; m_good = 1; end
        else m_pos = (m_pos + 1) % L;
      end else begin
        if (m_pos == 0) begin
          st = 1;
          if (sy) m_sbad = 0;
          else begin se = 1; m_sbad++; if (m_sbad == 4) drop = 1; end
        end else if (m_pos == 1) begin
          if (sc) m_cbad = 0;
          else begin str = 1; m_cbad++; if (m_cbad == 3) drop = 1; end
        end else if (m_pos == 2) mm = !sk;
        else if (m_pos == L - 1) str = !dg;
        else ms = sk;
        m_pos = (m_pos + 1) % L;
        if (drop) begin m_st = 0; m_pos = 0; m_good = 0; m_sbad = 0; m_cbad = 0; st = 0; end
      end
    end
    e = {st, (m_st == 2), str, se, ms, mm};
  endtask

  task automatic drive(input bit v, input bit lk, input logic [1:0] h,
                       input logic [63:0] d, input string tag);
    logic [5:0] e;
    @(negedge clk);
    blk_valid = v; blk_lock_in = lk; blk_hdr = h; blk_data = d;
    model(v, lk, h, d, e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // fault: 0 none, 1 skip in body, 2 skip slot missing, 3 bad scrambler,
  //        4 bad sync, 5 bad diag; gap inserts idle cycles after slot 4
  task automatic send_mf(input int fault, input int gap, input string tag);
    for (int i = 0; i < L; i++) begin
      if (i == 0)
        drive(1, 1, 2'b10, (fault == 4) ? 64'h2B00_0000_0000_0001 : W_SYNC, tag);
      else if (i == 1)
        drive(1, 1, 2'b10, (fault == 3) ? {8'h2A, 56'h0} : W_SCR, tag);
      else if (i == 2) begin
        if (fault == 2) drive(1, 1, 2'b01, 64'hDEAD_0000_0000_0002, tag);
        else            drive(1, 1, 2'b10, W_SKIP, tag);
      end else if (i == L - 1)
        drive(1, 1, 2'b10, (fault == 5) ? {8'h18, 56'h0} : W_DIAG, tag);
      else if (i == 6 && fault == 1)
        drive(1, 1, 2'b10, W_SKIP, tag);
      else
        drive(1, 1, 2'b01, {32'hC0DE_0000, 32'(i)}, tag);
      if (i == 4) for (int g = 0; g < gap; g++) drive(0, 1, 2'b10, W_SYNC, "R11");
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [5:0] e, got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {mf_start, mf_locked, mf_struct_err, sync_word_err, skip_misplaced, skip_missing};
      vectors++;
      if (got !== e) begin
        fails++;
        $display("FAIL %s: got %b expected %b", t, got, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    vectors++;
    if ({mf_start, mf_locked, mf_struct_err, sync_word_err, skip_misplaced, skip_missing} !== 6'b0) begin
      fails++;
      $display("FAIL R2: got %b expected %b",
        {mf_start, mf_locked, mf_struct_err, sync_word_err, skip_misplaced, skip_missing}, 6'b0);
    end
    rst = 1'b0;
    // R11 idle before lock
    for (int i = 0; i < 3; i++) drive(0, 1, 2'b10, W_SYNC, "R11");
    // R1: sync pattern with wrong header and near-miss payload do not start a candidate
    drive(1, 1, 2'b01, W_SYNC, "R1");
    drive(1, 1, 2'b10, W_SYNC ^ 64'h1, "R1");
    // R4: false candidate mid-stream, then real alignment
    drive(1, 1, 2'b10, W_SYNC, "R4");
    for (int i = 0; i < 4; i++) drive(1, 1, 2'b01, 64'(i), "R4");
    // R3 / R5: acquire lock over four frames
    for (int f = 0; f < 5; f++) send_mf(0, 0, "R3");
    send_mf(0, 3, "R11");
    send_mf(1, 0, "R8");
    send_mf(2, 0, "R9");
    send_mf(5, 0, "R7");
    send_mf(3, 0, "R7");
    send_mf(0, 0, "R5");
    // R6: three bad syncs then good keeps lock
    for (int f = 0; f < 3; f++) send_mf(4, 0, "R6");
    send_mf(0, 0, "R6");
    // R7: three consecutive bad scrambler words end lock
    for (int f = 0; f < 3; f++) send_mf(3, 0, "R7");
    for (int f = 0; f < 5; f++) send_mf(0, 0, "R3");
    // R6: four consecutive bad syncs end lock
    for (int f = 0; f < 4; f++) send_mf(4, 0, "R6");
    for (int f = 0; f < 5; f++) send_mf(0, 0, "R5");
    // R10: upstream block lock lost mid-frame
    for (int i = 0; i < 3; i++) drive(1, 1, 2'b01, 64'(i), "R10");
    for (int i = 0; i < 5; i++) drive(1, 0, 2'b10, W_SYNC, "R10");
    for (int i = 0; i < 2; i++) drive(1, 1, 2'b01, 64'(i), "R10");
    for (int f = 0; f < 5; f++) send_mf(0, 0, "R10");
    // R4: confirm interrupted by bad slot-0 word, then re-acquire
    for (int i = 0; i < 4; i++) drive(1, 0, 2'b10, W_SYNC, "R10");
    send_mf(0, 0, "R4");
    send_mf(4, 0, "R4");
    for (int f = 0; f < 5; f++) send_mf(0, 0, "R3");
    drive(0, 1, 2'b01, 64'h0, "R11");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule